// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block takes an asynchronous serial line and turns each received character into an 8-bit byte. The byte appears on a parallel output together with a strobe that lasts one clock. The block runs on the system clock. Its timing comes from an enable pulse that the surrounding logic supplies at sixteen times the bit rate. At a 50 MHz clock and 9600 baud, that is one single-cycle pulse every 325 clocks. The block has no divider of its own.

A character is framed as follows. The line rests high. The frame opens with one low start symbol, carries eight data symbols with the least-significant bit first, and closes with one high stop symbol. A falling edge on the synchronised line arms the receiver. The start symbol is confirmed only if the line is still low at its middle, so short spikes are discarded. Each data symbol is decided by a two-of-three vote of samples taken near mid-bit. The stop symbol is checked at its middle. The receiver then goes straight back to searching for an edge. Because of this, a following frame from a slightly fast sender is still caught, and every frame re-times itself from its own start edge.

The output is a stream with valid but no ready. A serial line cannot be paused, so there is no back-pressure. A consumer must take the byte in the strobe cycle, or read it later from the output, which holds its value until the next strobe.

Top module: `uart_os_rx`

## Requirements
- R1: A synchronous active-high reset drives `rx_valid_o` and `rx_ferr_o` low, clears `rx_byte_o` to 0x00 and returns the receiver to edge search.
- R2: A frame consisting of a low start symbol, eight data symbols least-significant bit first and a high stop symbol, each 16 enable pulses long, is delivered on `rx_byte_o` with the first data symbol in bit 0.
- R3: Every frame that is received produces exactly one strobe on `rx_valid_o`, one clock wide.
- R4: A low pulse that has ended by the 8th enable pulse after the falling edge is dropped as a false start and produces no byte. Any frame that follows it is received normally.
- R5: Each data symbol is the majority of the samples taken at enable pulses 7, 8 and 9 of that symbol, so one corrupted sample among the three does not change the byte.
- R6: If the stop symbol is low at its middle (enable pulse 8), `rx_ferr_o` is raised in the same cycle as the `rx_valid_o` strobe and the byte is still presented.
- R7: `rx_ferr_o` is never high without `rx_valid_o`.
- R8: Frames sent back to back with no idle time are all received, at bit periods up to about 3% shorter or longer than nominal, over at least five consecutive frames.
- R9: The strobe follows an enable pulse: `rx_valid_o` is high only in the cycle after `os_tick_i` was high.
- R10: `rx_byte_o` keeps its value in every cycle in which `rx_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| os_tick_i | input | 1 | Single-cycle enable pulse at 16x the bit rate |
| line_i | input | 1 | Asynchronous serial input, idle high |
| rx_byte_o | output | 8 | Last received byte, held between strobes |
| rx_valid_o | output | 1 | One-cycle strobe, byte on `rx_byte_o` is new |
| rx_ferr_o | output | 1 | Stop symbol was low; meaningful only with the strobe |

## Verification
The checker watches the relations between the output pins on every cycle: the reset values, the one-cycle width of the strobe, the framing flag appearing only with the strobe, the strobe following an enable pulse, and the byte holding steady between strobes. Whether the correct byte was recovered can only be shown by the bench scenarios. The same holds for spike rejection, for the vote outweighing a corrupted sample, for the framing error, and for catching every frame of a fast or slow back-to-back burst. In each of these the bench drives the line with a chosen bit period and compares the bytes collected at the outputs.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  // Receiver sequencing states
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,  // waiting for a falling edge
    ST_START = 2'd1,  // confirming the start symbol
    ST_DATA  = 2'd2,  // collecting data symbols
    ST_STOP  = 2'd3   // checking the stop symbol
  } rx_state_e;

  // Two-of-three majority
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] sr;
  logic              line_d;

  // Synchroniser chain, reset to the idle (high) level
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sr     <= '1;
      line_d <= 1'b1;
    end else begin
      sr     <= {sr[STAGES-2:0], line_i};
      line_d <= sr[STAGES-1];
    end
  end

  assign line_s_o = sr[STAGES-1];
  assign fall_o   = line_d & ~sr[STAGES-1];

endmodule

// File: rtl/uart_os_rx_vote.sv
module uart_os_rx_vote (
  input  logic clk_i,
  input  logic rst_i,
  input  logic line_s_i,
  input  logic cap_a_i,
  input  logic cap_b_i,
  output logic vote_o
);
  import uart_os_rx_pkg::*;

  logic smp_a, smp_b;

  // Hold the two earlier samples; the third is the live line
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      smp_a <= 1'b1;
      smp_b <= 1'b1;
    end else begin
      if (cap_a_i) smp_a <= line_s_i;
      if (cap_b_i) smp_b <= line_s_i;
    end
  end

  assign vote_o = maj3(smp_a, smp_b, line_s_i);

endmodule

// File: rtl/uart_os_rx_ctrl.sv
module uart_os_rx_ctrl #(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 tick_i,
  input  logic                 line_s_i,
  input  logic                 fall_i,
  input  logic                 vote_i,
  output logic                 cap_a_o,
  output logic                 cap_b_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 valid_o,
  output logic                 ferr_o
);
  import uart_os_rx_pkg::*;

  localparam int PH_W  = $clog2(OVS);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  // Phase value before the k-th pulse of a symbol is k-1
  localparam logic [PH_W-1:0]  PH_EARLY = PH_W'(OVS/2 - 2);  // pulse 7
  localparam logic [PH_W-1:0]  PH_MID   = PH_W'(OVS/2 - 1);  // pulse 8
  localparam logic [PH_W-1:0]  PH_LATE  = PH_W'(OVS/2);      // pulse 9
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  rx_state_e            state;
  logic [PH_W-1:0]      phase;
  logic [BIT_W-1:0]     bitn;
  logic [DATA_BITS-1:0] shreg;
  logic                 ph_last;

  assign ph_last = (phase == PH_LAST);
  assign cap_a_o = (state == ST_DATA) && tick_i && (phase == PH_EARLY);
  assign cap_b_o = (state == ST_DATA) && tick_i && (phase == PH_MID);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state   <= ST_HUNT;
      phase   <= '0;
      bitn    <= '0;
      shreg   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (fall_i) begin
            state <= ST_START;
            phase <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            phase <= ph_last ? '0 : phase + 1'b1;
            if (phase == PH_MID && line_s_i) begin
              state <= ST_HUNT;             // spike, not a start
            end else if (ph_last) begin
              state <= ST_DATA;
              bitn  <= '0;
            end
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            phase <= ph_last ? '0 : phase + 1'b1;
            if (phase == PH_LATE)
              shreg <= {vote_i, shreg[DATA_BITS-1:1]};
            if (ph_last) begin
              if (bitn == BIT_LAST) state <= ST_STOP;
              else                  bitn  <= bitn + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            phase <= phase + 1'b1;
            if (phase == PH_MID) begin
              byte_o  <= shreg;
              valid_o <= 1'b1;
              ferr_o  <= ~line_s_i;
              state   <= ST_HUNT;           // re-arm mid stop symbol
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OVS         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 os_tick_i,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] rx_byte_o,
  output logic                 rx_valid_o,
  output logic                 rx_ferr_o
);

  logic line_s, fall, vote, cap_a, cap_b;

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .line_i   (line_i),
    .line_s_o (line_s),
    .fall_o   (fall)
  );

  uart_os_rx_vote u_vote (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .line_s_i (line_s),
    .cap_a_i  (cap_a),
    .cap_b_i  (cap_b),
    .vote_o   (vote)
  );

  uart_os_rx_ctrl #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_i   (os_tick_i),
    .line_s_i (line_s),
    .fall_i   (fall),
    .vote_i   (vote),
    .cap_a_o  (cap_a),
    .cap_b_o  (cap_b),
    .byte_o   (rx_byte_o),
    .valid_o  (rx_valid_o),
    .ferr_o   (rx_ferr_o)
  );

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 os_tick_i,
  input logic [DATA_BITS-1:0] rx_byte_o,
  input logic                 rx_valid_o,
  input logic                 rx_ferr_o
);

  // R1: the cycle after reset, the strobes are low and the byte is cleared
  p_reset_clear_r1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!rx_valid_o && !rx_ferr_o && rx_byte_o == '0));

  // R3: the strobe is one clock wide
  p_strobe_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_valid_o |=> !rx_valid_o);

  // R7: the framing flag only comes with the strobe
  p_ferr_with_valid_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_ferr_o |-> rx_valid_o);

  // R9: the strobe follows an enable pulse
  p_strobe_after_tick_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rx_valid_o) |-> $past(os_tick_i));

  // R10: the byte holds between strobes
  p_byte_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !rx_valid_o |-> $stable(rx_byte_o));

endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .os_tick_i  (os_tick_i),
  .rx_byte_o  (rx_byte_o),
  .rx_valid_o (rx_valid_o),
  .rx_ferr_o  (rx_ferr_o)
);

// File: tb/uart_os_rx_tb.sv
`timescale 1ns/1ps
module uart_os_rx_tb;

  localparam int TICK_DIV = 8;              // clocks per enable pulse
  localparam int NOM      = 16 * TICK_DIV;  // clocks per bit, nominal

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       line = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_ferr;

  int n_chk = 0, n_bad = 0, got_n = 0;
  logic [7:0] got_b [0:31];
  logic       got_f [0:31];
  bit         done = 1'b0;

  always #10 clk = ~clk;

  uart_os_rx u_dut (
    .clk_i(clk), .rst_i(rst), .os_tick_i(tick), .line_i(line),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .rx_ferr_o(rx_ferr)
  );

  // Free-running enable pulse, driven away from the active edge
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == TICK_DIV - 1);
      c = (c == TICK_DIV - 1) ? 0 : c + 1;
    end
  end

  // Collector: one entry per strobe cycle
  always @(negedge clk) begin
    if (rx_valid) begin
      if (got_n < 32) begin
        got_b[got_n] = rx_byte;
        got_f[got_n] = rx_ferr;
      end
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int bits);
    line = 1'b1;
    repeat (bits * NOM) @(negedge clk);
  endtask

  // One frame; spike_bit >= 0 inverts that data symbol for 8 clocks at its middle
  task automatic send(input logic [7:0] b, input logic stop, input int cpb,
                      input int spike_bit);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int k = 0; k < cpb; k++) begin
        @(negedge clk);
        if (spike_bit >= 0 && i == spike_bit + 1 && k >= cpb/2 - 4 && k < cpb/2 + 4)
          line = ~fr[i];
        else
          line = fr[i];
      end
    end
    @(negedge clk);
    line = 1'b1;
  endtask

  task automatic expect_bytes(input int first, input logic [7:0] b, input logic f,
                              input string req);
    chk(got_b[first] == b, req, got_b[first], b);
    chk(got_f[first] == f, req, got_f[first], f);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rx_valid && !rx_ferr, "R1 strobes after reset", {rx_valid, rx_ferr}, 0);
    chk(rx_byte == 8'h00, "R1 byte after reset", rx_byte, 0);
    idle(2);
  endtask

  task automatic t_basic;
    int s = got_n;
    send(8'hA5, 1'b1, NOM, -1);
    idle(1);
    chk(got_n == s + 1, "R3 one strobe per frame", got_n - s, 1);
    expect_bytes(s, 8'hA5, 1'b0, "R2 byte A5");
    idle(2);
    chk(rx_byte == 8'hA5, "R10 byte held while idle", rx_byte, 8'hA5);
  endtask

  task automatic t_patterns;
    logic [7:0] pat [4] = '{8'h00, 8'hFF, 8'h01, 8'h80};
    int s = got_n;
    for (int i = 0; i < 4; i++) begin
      send(pat[i], 1'b1, NOM, -1);
      idle(1);
    end
    chk(got_n == s + 4, "R3 strobes for four frames", got_n - s, 4);
    for (int i = 0; i < 4; i++) expect_bytes(s + i, pat[i], 1'b0, "R2 bit order");
  endtask

  task automatic t_glitch;
    int s = got_n;
    line = 1'b0; repeat (3 * TICK_DIV) @(negedge clk);
    idle(12);
    line = 1'b0; repeat (5 * TICK_DIV) @(negedge clk);
    idle(12);
    chk(got_n == s, "R4 spikes give no byte", got_n - s, 0);
    send(8'h3C, 1'b1, NOM, -1);
    idle(1);
    chk(got_n == s + 1, "R4 frame after spikes", got_n - s, 1);
    expect_bytes(s, 8'h3C, 1'b0, "R4 byte after spikes");
  endtask

  task automatic t_vote;
    int s = got_n;
    send(8'h00, 1'b1, NOM, 3);
    idle(1);
    send(8'hFF, 1'b1, NOM, 6);
    idle(1);
    chk(got_n == s + 2, "R5 strobes", got_n - s, 2);
    expect_bytes(s,     8'h00, 1'b0, "R5 spike high outvoted");
    expect_bytes(s + 1, 8'hFF, 1'b0, "R5 spike low outvoted");
  endtask

  task automatic t_framing;
    int s = got_n;
    send(8'h5A, 1'b0, NOM, -1);
    idle(3);
    chk(got_n == s + 1, "R6 strobe on bad stop", got_n - s, 1);
    expect_bytes(s, 8'h5A, 1'b1, "R6 framing flag and byte");
    send(8'hC3, 1'b1, NOM, -1);
    idle(1);
    expect_bytes(s + 1, 8'hC3, 1'b0, "R7 flag clear on good frame");
  endtask

  task automatic t_rate(input int cpb, input string req);
    logic [7:0] seq [5] = '{8'h48, 8'h65, 8'h6C, 8'h6C, 8'h6F};
    int s = got_n;
    for (int i = 0; i < 5; i++) send(seq[i], 1'b1, cpb, -1);
    idle(2);
    chk(got_n == s + 5, req, got_n - s, 5);
    for (int i = 0; i < 5; i++) expect_bytes(s + i, seq[i], 1'b0, req);
  endtask

  task automatic t_reset_mid;
    int s = got_n;
    line = 1'b0;
    repeat (4 * NOM) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rx_valid, "R1 no strobe in reset", rx_valid, 0);
    rst = 1'b0;
    idle(12);
    chk(got_n == s, "R1 aborted frame dropped", got_n - s, 0);
    send(8'h96, 1'b1, NOM, -1);
    idle(1);
    expect_bytes(s, 8'h96, 1'b0, "R1 frame after reset");
  endtask

  initial begin
    t_reset;
    t_basic;
    t_patterns;
    t_glitch;
    t_vote;
    t_framing;
    t_rate(NOM - 4, "R8 fast burst");
    t_rate(NOM + 4, "R8 slow burst");
    t_reset_mid;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule